// File: doc/BRIEF.md
# Power-Management Command Port

This block gives system firmware a two-byte I/O window for power-management requests. It decodes byte accesses on a simple I/O bus. The window holds a command register and a scratch status register. Writing the command register does two things: it stores the byte, and it sends a one-cycle event carrying that byte to downstream logic, such as an interrupt generator for the management mode. Writing the status register only stores the byte. Firmware uses it as a mailbox.

The window sits at a fixed, even base address, which defaults to 0xB2. Inside the window, address bit 0 chooses the register. Any access outside the window is left alone, so another decoder on the same bus can answer it. Read data is registered and comes with a valid flag. A registered hit flag marks every access that the block claimed.

Top module: `pm_cmd_port`

## Requirements
- R1: While reset is high and after it is released, both registers hold 0x00, and `cmd_evt`, `io_rvalid` and `io_hit` are low. `io_rdata` is 0x00.
- R2: An access is in the window only when `io_addr[15:1]` equals `BASE_ADDR[15:1]`. With the default base, the window is 0xB2 and 0xB3. `io_addr[0]`=0 selects the command register, and `io_addr[0]`=1 selects the status register.
- R3: A write to the command register stores `io_wdata`. In the next cycle `cmd_evt` is high for one cycle, and `cmd_evt_data` equals the written byte.
- R4: A write to the status register stores `io_wdata` and never raises `cmd_evt`.
- R5: A read in the window gives `io_rvalid`=1 in the next cycle, with `io_rdata` equal to the selected register. A read has no side effect; in particular, it raises no event. While `io_rvalid` is low, `io_rdata` is 0x00.
- R6: An access outside the window stores nothing, raises no event and gives no `io_rvalid`.
- R7: Command writes in consecutive cycles keep `cmd_evt` high in each following cycle. Each cycle carries its own byte, even when the bytes repeat.
- R8: A read and a write to the same register in one cycle return the value held before that write.
- R9: `io_hit` is high in the cycle after any read or write in the window. It is low after an access outside the window or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | Write enable |
| io_rd | input | 1 | Read enable |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, 0 when not valid |
| io_rvalid | output | 1 | Read data valid |
| io_hit | output | 1 | Previous cycle's access was claimed |
| cmd_evt | output | 1 | One-cycle command event strobe |
| cmd_evt_data | output | 8 | Command byte for the event |

## Verification
Every result is due exactly one clock after the edge that takes the access: the event strobe and its byte, read data with its valid flag, and the hit flag. A stored value is first visible to a read issued in that same following cycle. The bench drives each access on a falling edge. It checks on the next falling edge, which is one rising edge later. This way each check lands in the single cycle where the result is due, and the cycle after it is checked for the strobe dropping. For the same-cycle read and write case, the read result is checked in that following cycle against the old value. A second read then checks the new one.

// File: rtl/pm_cmd_pkg.sv
package pm_cmd_pkg;
  localparam int NREG  = 2;
  localparam int SEL_W = $clog2(NREG);
  localparam logic [SEL_W-1:0] SEL_CMD  = 1'b0;
  localparam logic [SEL_W-1:0] SEL_STAT = 1'b1;

  typedef struct packed {
    logic             in_win;
    logic             wr;
    logic             rd;
    logic [SEL_W-1:0] sel;
  } pm_acc_t;
endpackage

// File: rtl/pm_cmd_decode.sv
module pm_cmd_decode
  import pm_cmd_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00B2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output pm_acc_t           acc
);
  localparam logic [ADDR_W-2:0] WIN_TAG = BASE_ADDR[ADDR_W-1:1];

  logic in_win;
  assign in_win = (addr[ADDR_W-1:1] == WIN_TAG);

  always_comb begin
    acc.in_win = in_win;
    acc.wr     = in_win & wr;
    acc.rd     = in_win & rd;
    acc.sel    = addr[SEL_W-1:0];
  end
endmodule

// File: rtl/pm_cmd_regs.sv
module pm_cmd_regs
  import pm_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NREG-1:0][DATA_W-1:0]  regs_q,
  output logic                         evt_q,
  output logic [DATA_W-1:0]            evt_data_q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[i] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(i)))
        regs_q[i] <= wdata;
    end
  end

  logic cmd_wr;
  assign cmd_wr = wr_en && (wr_sel == SEL_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q      <= 1'b0;
      evt_data_q <= '0;
    end else begin
      evt_q <= cmd_wr;
      if (cmd_wr)
        evt_data_q <= wdata;
    end
  end
endmodule

// File: rtl/pm_cmd_rdport.sv
module pm_cmd_rdport
  import pm_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic [SEL_W-1:0]             rd_sel,
  input  logic                         claim,
  input  logic [NREG-1:0][DATA_W-1:0]  regs_q,
  output logic [DATA_W-1:0]            rdata_q,
  output logic                         rvalid_q,
  output logic                         hit_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      hit_q    <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      rdata_q  <= rd_en ? regs_q[rd_sel] : '0;
      hit_q    <= claim;
    end
  end
endmodule

// File: rtl/pm_cmd_port.sv
module pm_cmd_port
  import pm_cmd_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00B2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rvalid,
  output logic              io_hit,
  output logic              cmd_evt,
  output logic [DATA_W-1:0] cmd_evt_data
);
  pm_acc_t                     acc;
  logic [NREG-1:0][DATA_W-1:0] regs_q;
  logic                        claim;

  assign claim = acc.in_win & (io_wr | io_rd);

  pm_cmd_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr (io_addr),
    .wr   (io_wr),
    .rd   (io_rd),
    .acc  (acc)
  );

  pm_cmd_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (acc.wr),
    .wr_sel     (acc.sel),
    .wdata      (io_wdata),
    .regs_q     (regs_q),
    .evt_q      (cmd_evt),
    .evt_data_q (cmd_evt_data)
  );

  pm_cmd_rdport #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (acc.rd),
    .rd_sel   (acc.sel),
    .claim    (claim),
    .regs_q   (regs_q),
    .rdata_q  (io_rdata),
    .rvalid_q (io_rvalid),
    .hit_q    (io_hit)
  );
endmodule

// File: rtl/pm_cmd_port_chk.sv
module pm_cmd_port_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00B2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [DATA_W-1:0] io_wdata,
  input logic [DATA_W-1:0] io_rdata,
  input logic              io_rvalid,
  input logic              io_hit,
  input logic              cmd_evt,
  input logic [DATA_W-1:0] cmd_evt_data
);
  logic win, cmd_w;
  assign win   = (io_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
  assign cmd_w = win && io_wr && !io_addr[0];

  // R3: the event and its byte follow a command write
  a_r3_evt_follows_write: assert property (@(posedge clk) disable iff (rst)
    cmd_w |=> (cmd_evt && cmd_evt_data == $past(io_wdata)));

  // R4, R6: no event without a command write
  a_r4_no_spurious_evt: assert property (@(posedge clk) disable iff (rst)
    !cmd_w |=> !cmd_evt);

  // R5: a read in the window gives valid data next cycle
  a_r5_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    (io_rd && win) |=> io_rvalid);

  // R6: no valid data without a read in the window
  a_r6_no_rvalid_outside: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && win) |=> !io_rvalid);

  // R5: read data is zero while not valid
  a_r5_rdata_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !io_rvalid |-> (io_rdata == '0));

  // R9: hit follows only accesses in the window
  a_r9_hit_tracks_claim: assert property (@(posedge clk) disable iff (rst)
    ((io_wr || io_rd) && win) |=> io_hit);
  a_r9_no_hit_outside: assert property (@(posedge clk) disable iff (rst)
    !((io_wr || io_rd) && win) |=> !io_hit);
endmodule

bind pm_cmd_port pm_cmd_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
  .io_hit(io_hit), .cmd_evt(cmd_evt), .cmd_evt_data(cmd_evt_data)
);

// File: tb/pm_cmd_port_test.sv
module pm_cmd_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid, io_hit, cmd_evt;
  logic [7:0]  cmd_evt_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [15:0] A_CMD  = 16'h00B2;
  localparam logic [15:0] A_STAT = 16'h00B3;

  always #4 clk = ~clk;

  pm_cmd_port uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .io_hit(io_hit), .cmd_evt(cmd_evt), .cmd_evt_data(cmd_evt_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    io_wr = 0; io_rd = 0;
  endtask

  // one write; returns on the negedge where the results are due
  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1; io_rd = 0;
    @(negedge clk); idle();
  endtask

  task automatic do_read(input logic [15:0] a);
    @(negedge clk); io_addr = a; io_rd = 1; io_wr = 0;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    chk("R1 evt", {7'b0, cmd_evt}, 8'h00);
    chk("R1 rvalid", {7'b0, io_rvalid}, 8'h00);
    chk("R1 hit", {7'b0, io_hit}, 8'h00);
    chk("R1 rdata", io_rdata, 8'h00);
    do_read(A_CMD);  chk("R1 cmd reg", io_rdata, 8'h00);
    do_read(A_STAT); chk("R1 stat reg", io_rdata, 8'h00);
  endtask

  task automatic t_cmd_write();
    do_write(A_CMD, 8'hA5);
    chk("R3 evt", {7'b0, cmd_evt}, 8'h01);
    chk("R3 evt_data", cmd_evt_data, 8'hA5);
    chk("R9 hit on write", {7'b0, io_hit}, 8'h01);
    @(negedge clk);
    chk("R3 evt one cycle", {7'b0, cmd_evt}, 8'h00);
    chk("R9 hit idle", {7'b0, io_hit}, 8'h00);
    do_read(A_CMD);
    chk("R5 rvalid", {7'b0, io_rvalid}, 8'h01);
    chk("R2 R3 cmd readback", io_rdata, 8'hA5);
    chk("R5 read no evt", {7'b0, cmd_evt}, 8'h00);
    @(negedge clk);
    chk("R5 rdata zero when idle", io_rdata, 8'h00);
  endtask

  task automatic t_stat_write();
    do_write(A_STAT, 8'h3C);
    chk("R4 no evt", {7'b0, cmd_evt}, 8'h00);
    do_read(A_STAT); chk("R2 R4 stat readback", io_rdata, 8'h3C);
    do_read(A_CMD);  chk("R4 cmd untouched", io_rdata, 8'hA5);
  endtask

  task automatic t_outside();
    do_write(16'h00B4, 8'h77);
    chk("R6 no evt B4", {7'b0, cmd_evt}, 8'h00);
    chk("R9 no hit B4", {7'b0, io_hit}, 8'h00);
    do_write(16'h00B1, 8'h66);
    chk("R6 no hit B1", {7'b0, io_hit}, 8'h00);
    do_write(16'h01B2, 8'h55);
    chk("R2 alias 01B2 no evt", {7'b0, cmd_evt}, 8'h00);
    do_read(16'h00B4);
    chk("R6 no rvalid", {7'b0, io_rvalid}, 8'h00);
    chk("R6 rdata zero", io_rdata, 8'h00);
    do_read(A_CMD);  chk("R6 cmd kept", io_rdata, 8'hA5);
    do_read(A_STAT); chk("R6 stat kept", io_rdata, 8'h3C);
  endtask

  task automatic t_back_to_back();
    @(negedge clk); io_addr = A_CMD; io_wr = 1; io_wdata = 8'h11;
    @(negedge clk);
    chk("R7 evt 1", {7'b0, cmd_evt}, 8'h01); chk("R7 data 1", cmd_evt_data, 8'h11);
    io_wdata = 8'h11;
    @(negedge clk);
    chk("R7 evt 2 same value", {7'b0, cmd_evt}, 8'h01); chk("R7 data 2", cmd_evt_data, 8'h11);
    io_wdata = 8'h22;
    @(negedge clk); idle();
    chk("R7 evt 3", {7'b0, cmd_evt}, 8'h01); chk("R7 data 3", cmd_evt_data, 8'h22);
    @(negedge clk);
    chk("R7 evt drops", {7'b0, cmd_evt}, 8'h00);
  endtask

  task automatic t_same_cycle();
    @(negedge clk); io_addr = A_STAT; io_wdata = 8'h99; io_wr = 1; io_rd = 1;
    @(negedge clk); idle();
    chk("R8 old value", io_rdata, 8'h3C);
    chk("R8 rvalid", {7'b0, io_rvalid}, 8'h01);
    do_read(A_STAT); chk("R8 new value", io_rdata, 8'h99);
    @(negedge clk); io_addr = A_CMD; io_wdata = 8'h5A; io_wr = 1; io_rd = 1;
    @(negedge clk); idle();
    chk("R8 cmd old value", io_rdata, 8'h22);
    chk("R8 cmd evt", {7'b0, cmd_evt}, 8'h01);
  endtask

  task automatic t_reset_mid();
    @(negedge clk); rst = 1; io_addr = A_CMD; io_wr = 1; io_wdata = 8'hEE;
    @(negedge clk);
    chk("R1 no evt in reset", {7'b0, cmd_evt}, 8'h00);
    idle(); rst = 0;
    do_read(A_CMD);  chk("R1 cmd cleared", io_rdata, 8'h00);
    do_read(A_STAT); chk("R1 stat cleared", io_rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_cmd_write();
    t_stat_write();
    t_outside();
    t_back_to_back();
    t_same_cycle();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule